// File: doc/BRIEF.md
# Eight-Pin Masked-Access GPIO Port with Interrupt Detection

This block is an 8-pin general-purpose I/O port that sits behind a simple single-cycle register bus. Software sets each pin as an input or an output. Outputs are driven through a data window. In that window the word address is also a per-pin select, so one access can read or change any chosen subset of pins without a read-modify-write.

Each pin has its own interrupt detector. It can trigger on a falling edge, a rising edge, either edge, a low level or a high level. Edge events are latched in a raw status register, and software clears them by writing ones. A ninth status source latches a completion pulse from an external DMA engine. A mask register decides which sources reach the single interrupt output. A port-level enable also turns detected pin events into a DMA request pulse, and the interrupt path keeps working as configured.

Bus writes take effect on the rising clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational while `bus_sel` is high and `bus_wr` is low. Pin inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `mgpio_port`

## Requirements
- R1: While reset is asserted and after it is released, all control and status state is zero. `pin_oe`, `pin_out`, `irq_out` and `dma_req_out` are 0, and the direction, mask, raw-status and DMA-enable registers read 0.
- R2: The direction register at offset 0x400 holds one bit per pin, with bit n for pin n. A 1 makes the pin an output, and `pin_oe[n]` follows that bit. The register reads back what was written.
- R3: Offsets whose bits [11:10] are 00 form the data window, and address bits [9:2] are the pin select. A write changes the output latch (`pin_out`) only for pins that are both selected and configured as outputs. All other latch bits keep their value.
- R4: A data-window read returns, for each selected pin, the output latch if the pin is an output or the synchronized input level if it is an input. Unselected bits read 0, and bits 31:8 read 0.
- R5: With the level bit (0x408) and the any-edge bit (0x404) both clear, the polarity bit (0x40C) chooses the edge. A 1 selects rising and a 0 selects falling. A detected edge sets the pin's raw status bit (offset 0x414, bit n). That bit is readable after the third rising clock edge that follows the pin change.
- R6: With the any-edge bit set and the level bit clear, both edges set raw status, whatever the polarity bit holds.
- R7: With the level bit set, the pin's raw status bit follows the synchronized pin level: active high when polarity is 1, active low when it is 0. The level bit overrides the any-edge bit, and a clear write does not change a level-sensed bit.
- R8: Writing to the clear register at 0x41C clears each latched raw status bit whose data bit is 1. Bits written as 0 leave their status unchanged.
- R9: The mask register at 0x410 has 9 bits, bit 8 being the DMA-done source. The masked status at 0x418 equals raw status AND mask. `irq_out` is high exactly when any masked status bit is set.
- R10: A high `dma_done_in` sampled on a clock edge sets raw status bit 8. The bit stays set until a clear write with bit 8 = 1; writing 0 in bit 8 leaves it set.
- R11: When bit 0 of the DMA-enable register at 0x420 is 1, `dma_req_out` is high in every cycle in which a pin meets its configured sense condition. For an edge this is a single cycle, two clock edges after the pin change. When the enable bit is 0, `dma_req_out` stays 0. Raw status and `irq_out` behave the same either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch value per pin |
| pin_oe | output | 8 | Output enable per pin (direction) |
| dma_done_in | input | 1 | Completion pulse from the DMA engine |
| irq_out | output | 1 | Combined masked interrupt |
| dma_req_out | output | 1 | DMA request on pin activity when enabled |

## Verification
Four groups of checks run on every clock cycle:
- Pins that are not selected, or not configured as outputs, keep their output latch.
- Data-window reads return nothing outside the select mask.
- A latched edge bit drops only after a clear write or a switch to level sensing, and an edge seen in edge mode is latched on the next cycle.
- The interrupt and DMA request outputs never rise without a mask bit or the enable bit.

The bench has to show the rest: the pipeline latency, the mode encodings, whether the correct status value is read back, and the persistence of level-sensed status across a clear. To do this it sweeps every sense mode on every pin, and every select mask under four direction patterns.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_DIR   = 4'd0,
    REG_ANY   = 4'd1,
    REG_LEVEL = 4'd2,
    REG_HIGH  = 4'd3,
    REG_MASK  = 4'd4,
    REG_RAW   = 4'd5,
    REG_MSTAT = 4'd6,
    REG_CLR   = 4'd7,
    REG_DMAEN = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_sync = sync_q;
  assign q_prev = prev_q;
endmodule

// File: rtl/mgpio_sense.sv
module mgpio_sense #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_now,
  input  logic [NPINS-1:0] lvl_prev,
  input  logic [NPINS-1:0] sel_any,
  input  logic [NPINS-1:0] sel_level,
  input  logic [NPINS-1:0] sel_high,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] raw
);
  logic [NPINS-1:0] edge_q, edge_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_now[g] & ~lvl_prev[g];
    assign fall = ~lvl_now[g] & lvl_prev[g];

    always_comb begin
      if (sel_level[g])      hit[g] = sel_high[g] ? lvl_now[g] : ~lvl_now[g];
      else if (sel_any[g])   hit[g] = rise | fall;
      else                   hit[g] = sel_high[g] ? rise : fall;
      edge_d[g] = sel_level[g] ? 1'b0 : (hit[g] | (edge_q[g] & ~clr[g]));
      raw[g]    = sel_level[g] ? hit[g] : edge_q[g];
    end

    // R5: an edge seen in edge mode is latched on the next cycle
    a_r5_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_level[g] && hit[g]) |=> edge_q[g]);
    // R6: any-edge mode latches every change of the synchronized level
    a_r6_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_level[g] && sel_any[g] && (lvl_now[g] != lvl_prev[g])) |=> edge_q[g]);
    // R7: level sensing keeps no latched state
    a_r7_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_level[g] && $past(sel_level[g])) |-> !edge_q[g]);
    // R8: a latched bit only drops on a clear or a switch to level mode
    a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(edge_q[g]) |-> ($past(clr[g]) || $past(sel_level[g])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= '0;
    else        edge_q <= edge_d;
  end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic             dma_done_in,
  output logic             irq_out,
  output logic             dma_req_out
);
  localparam int NSRC    = NPINS + 1;
  localparam int WIN_LSB = 2;
  localparam int WIN_MSB = NPINS + 1;
  localparam int CFG_BIT = NPINS + 2;

  logic [NPINS-1:0] s_now, s_prev, hit, raw_pins, clr_pins, win_mask;
  logic [NPINS-1:0] dir_q, dir_d, any_q, any_d, lvl_q, lvl_d, high_q, high_d, dout_q, dout_d;
  logic [NSRC-1:0]  mask_q, mask_d, raw_all, mstat, clr_vec;
  logic             dmaen_q, dmaen_d, done_q, done_d;
  logic             wr_en, rd_en, upper_zero, in_win, in_cfg, win_wr, cfg_wr;
  reg_idx_e         idx;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[DW-1:NSRC], bus_addr[1:0]};

  mgpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(s_now), .q_prev(s_prev)
  );

  mgpio_sense #(.NPINS(NPINS)) u_sense (
    .clk(clk), .rst_n(rst_n), .lvl_now(s_now), .lvl_prev(s_prev),
    .sel_any(any_q), .sel_level(lvl_q), .sel_high(high_q),
    .clr(clr_pins), .hit(hit), .raw(raw_pins)
  );

  // Address decode
  assign wr_en      = bus_sel & bus_wr;
  assign rd_en      = bus_sel & ~bus_wr;
  assign upper_zero = (bus_addr[AW-1:CFG_BIT+1] == '0);
  assign in_win     = upper_zero & ~bus_addr[CFG_BIT];
  assign in_cfg     = upper_zero & bus_addr[CFG_BIT] & (bus_addr[CFG_BIT-1:IDX_W+2] == '0);
  assign idx        = reg_idx_e'(bus_addr[IDX_W+1:2]);
  assign win_mask   = bus_addr[WIN_MSB:WIN_LSB];
  assign win_wr     = wr_en & in_win;
  assign cfg_wr     = wr_en & in_cfg;

  assign clr_vec  = (cfg_wr && idx == REG_CLR) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_pins = clr_vec[NPINS-1:0];
  assign raw_all  = {done_q, raw_pins};
  assign mstat    = raw_all & mask_q;

  // Next-state logic
  always_comb begin
    dir_d   = dir_q;
    any_d   = any_q;
    lvl_d   = lvl_q;
    high_d  = high_q;
    mask_d  = mask_q;
    dmaen_d = dmaen_q;
    if (cfg_wr) begin
      case (idx)
        REG_DIR:   dir_d   = bus_wdata[NPINS-1:0];
        REG_ANY:   any_d   = bus_wdata[NPINS-1:0];
        REG_LEVEL: lvl_d   = bus_wdata[NPINS-1:0];
        REG_HIGH:  high_d  = bus_wdata[NPINS-1:0];
        REG_MASK:  mask_d  = bus_wdata[NSRC-1:0];
        REG_DMAEN: dmaen_d = bus_wdata[0];
        default:   ;
      endcase
    end
    dout_d = dout_q;
    if (win_wr)
      dout_d = (dout_q & ~(win_mask & dir_q)) | (bus_wdata[NPINS-1:0] & win_mask & dir_q);
    done_d = dma_done_in | (done_q & ~clr_vec[NPINS]);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      any_q   <= '0;
      lvl_q   <= '0;
      high_q  <= '0;
      mask_q  <= '0;
      dmaen_q <= 1'b0;
      dout_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      any_q   <= any_d;
      lvl_q   <= lvl_d;
      high_q  <= high_d;
      mask_q  <= mask_d;
      dmaen_q <= dmaen_d;
      dout_q  <= dout_d;
      done_q  <= done_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (in_win) begin
        bus_rdata[NPINS-1:0] = win_mask & ((dir_q & dout_q) | (~dir_q & s_now));
      end else if (in_cfg) begin
        case (idx)
          REG_DIR:   bus_rdata[NPINS-1:0] = dir_q;
          REG_ANY:   bus_rdata[NPINS-1:0] = any_q;
          REG_LEVEL: bus_rdata[NPINS-1:0] = lvl_q;
          REG_HIGH:  bus_rdata[NPINS-1:0] = high_q;
          REG_MASK:  bus_rdata[NSRC-1:0]  = mask_q;
          REG_RAW:   bus_rdata[NSRC-1:0]  = raw_all;
          REG_MSTAT: bus_rdata[NSRC-1:0]  = mstat;
          REG_DMAEN: bus_rdata[0]         = dmaen_q;
          default:   ;
        endcase
      end
    end
  end

  assign pin_out     = dout_q;
  assign pin_oe      = dir_q;
  assign irq_out     = |mstat;
  assign dma_req_out = dmaen_q & (|hit);

  // R2: a direction write shows on the enables one cycle later
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && idx == REG_DIR) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));
  // R3: no window write, no latch change
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(pin_out));
  // R3: a window write only touches selected output pins
  a_r3_select_only: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> (((pin_out ^ $past(pin_out)) & ~($past(win_mask) & $past(pin_oe))) == '0));
  // R4: window reads carry nothing outside the select
  a_r4_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_win) |-> ((bus_rdata & ~DW'(win_mask)) == '0));
  // R9: the interrupt needs at least one enabled source
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_q != '0));
  // R10: a completion pulse is latched
  a_r10_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_in |=> done_q);
  // R11: no request without the enable
  a_r11_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_out |-> dmaen_q);
endmodule

// File: tb/mgpio_port_test.sv
`timescale 1ns/1ps
module mgpio_port_test;
  localparam logic [11:0] A_DIR = 12'h400, A_ANY = 12'h404, A_LVL = 12'h408, A_HIGH = 12'h40C,
                          A_MASK = 12'h410, A_RAW = 12'h414, A_MST = 12'h418, A_CLR = 12'h41C,
                          A_DEN = 12'h420;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe;
  logic        dma_done_in, irq_out, dma_req_out;
  int          nvec = 0;
  int          nfail = 0;

  always #10 clk = ~clk;

  mgpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .dma_done_in(dma_done_in), .irq_out(irq_out), .dma_req_out(dma_req_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  dout_m, dir_v, w;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 8'h00; dma_done_in = 1'b0;
    tick(3);
    // R1: outputs during reset
    chk("R1 oe", {24'h0, pin_oe}, 32'h0);
    chk("R1 out", {24'h0, pin_out}, 32'h0);
    chk("R1 irq/req", {30'h0, irq_out, dma_req_out}, 32'h0);
    rst_n = 1'b1;
    tick(2);
    brd(A_DIR, rd);  chk("R1 dir", rd, 32'h0);
    brd(A_MASK, rd); chk("R1 mask", rd, 32'h0);
    brd(A_RAW, rd);  chk("R1 raw", rd, 32'h0);
    brd(A_DEN, rd);  chk("R1 dmaen", rd, 32'h0);

    // Sense sweep: mode 0 fall, 1 rise, 2 any-edge (polarity 0), 3 low level, 4 high level
    for (int m = 0; m < 5; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] b, e_base, e_rise, e_clr, e_fall;
        string tg;
        b = 8'(1 << i);
        tg = (m < 2) ? "R5" : (m == 2) ? "R6" : "R7";
        e_base = (m == 3) ? 8'hFF : 8'h00;
        e_rise = (m == 0) ? 8'h00 : (m == 3) ? ~b : b;
        e_clr  = (m == 3) ? ~b : (m == 4) ? b : 8'h00;
        e_fall = (m == 0 || m == 2) ? b : (m == 3) ? 8'hFF : 8'h00;
        pin_in = 8'h00;
        bwr(A_ANY,  (m == 2) ? 32'hFF : 32'h0);
        bwr(A_LVL,  (m >= 3) ? 32'hFF : 32'h0);
        bwr(A_HIGH, (m == 1 || m == 4) ? 32'hFF : 32'h0);
        bwr(A_MASK, 32'h0FF);
        tick(4);
        bwr(A_CLR, 32'h1FF);
        brd(A_RAW, rd); chk({tg, " idle"}, rd, {24'h0, e_base});
        pin_in = b;
        tick(3);
        brd(A_RAW, rd); chk({tg, " after rise"}, rd, {24'h0, e_rise});
        chk("R9 irq after rise", {31'h0, irq_out}, {31'h0, (e_rise != 0)});
        bwr(A_CLR, {23'h0, 1'b1, ~b});
        brd(A_RAW, rd); chk("R8 zero bits keep", rd, {24'h0, e_rise});
        bwr(A_CLR, 32'h0FF);
        brd(A_RAW, rd); chk("R8/R7 after clear", rd, {24'h0, e_clr});
        pin_in = 8'h00;
        tick(3);
        brd(A_RAW, rd); chk({tg, " after fall"}, rd, {24'h0, e_fall});
      end
    end
    bwr(A_ANY, 0); bwr(A_LVL, 0); bwr(A_HIGH, 0); bwr(A_MASK, 0);

    // Data window sweep
    pin_in = 8'h69;
    tick(3);
    bwr(A_CLR, 32'h1FF);
    dout_m = 8'h00;
    for (int k = 0; k < 4; k++) begin
      dir_v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
      bwr(A_DIR, {24'h0, dir_v});
      chk("R2 oe", {24'h0, pin_oe}, {24'h0, dir_v});
      brd(A_DIR, rd); chk("R2 readback", rd, {24'h0, dir_v});
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mk;
        mk = 8'(m);
        w = 8'(m * 37 + k * 91);
        bwr(12'(m << 2), {24'hABCDEF, w});
        dout_m = (dout_m & ~(mk & dir_v)) | (w & mk & dir_v);
        chk("R3 latch", {24'h0, pin_out}, {24'h0, dout_m});
        brd(12'(m << 2), rd);
        chk("R4 read", rd, {24'h0, mk & ((dir_v & dout_m) | (~dir_v & 8'h69))});
      end
    end
    bwr(A_DIR, 0);
    pin_in = 8'h00;
    tick(3);

    // DMA-done source
    bwr(A_HIGH, 32'hFF);
    bwr(A_CLR, 32'h1FF);
    dma_done_in = 1'b1;
    tick(1);
    dma_done_in = 1'b0;
    brd(A_RAW, rd); chk("R10 done latched", rd, 32'h100);
    chk("R9 irq masked off", {31'h0, irq_out}, 32'h0);
    bwr(A_MASK, 32'h100);
    chk("R9 irq on", {31'h0, irq_out}, 32'h1);
    brd(A_MST, rd); chk("R9 mstat", rd, 32'h100);
    bwr(A_CLR, 32'h0FF);
    brd(A_RAW, rd); chk("R10 zero keeps", rd, 32'h100);
    bwr(A_CLR, 32'h100);
    brd(A_RAW, rd); chk("R10 cleared", rd, 32'h0);
    chk("R9 irq off", {31'h0, irq_out}, 32'h0);

    // DMA trigger
    bwr(A_MASK, 32'h001);
    pin_in = 8'h01;
    tick(2);
    chk("R11 req disabled", {31'h0, dma_req_out}, 32'h0);
    tick(1);
    brd(A_RAW, rd); chk("R11 raw without dma", rd, 32'h1);
    pin_in = 8'h00;
    tick(3);
    bwr(A_CLR, 32'h1FF);
    bwr(A_DEN, 32'h1);
    pin_in = 8'h01;
    tick(1);
    chk("R11 req not early", {31'h0, dma_req_out}, 32'h0);
    tick(1);
    chk("R11 req pulse", {31'h0, dma_req_out}, 32'h1);
    tick(1);
    chk("R11 req one cycle", {31'h0, dma_req_out}, 32'h0);
    brd(A_RAW, rd); chk("R11 raw with dma", rd, 32'h1);
    chk("R11 irq with dma", {31'h0, irq_out}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule